// File: doc/BRIEF.md
# Dual event performance counter unit

This block holds two hardware event counters that a processor core programs and reads over a small register bus. Each counter has a 16-bit control word and a 48-bit count. The control word picks one 6-bit event code, holds a run flag and an arm flag, and carries a write-only clear request. The core also sees a stored clock-source flag in the control word. That flag is only kept and read back.

Events reach the block on a 64-wide strobe vector, with one strobe line per code. Code 0x23 is different. It ignores its strobe line and counts every clock cycle, so it measures elapsed time. Only a fixed, sparse set of codes is accepted. Any other code leaves its counter untouched.

The 48-bit count is read in two words. Reading the high word captures the low 32 bits into a per-counter shadow. The next read of the low word returns that shadow, so software gets a consistent 48-bit value while the counter keeps running. The count wraps at 2^48 and raises no overflow signal.

Top module: `perf_evt_pair`

## Requirements
- R1: After reset, every mapped register reads 0.
- R2: A control write stores bits 15 (run), 14 (arm), 8 (clock-source flag) and 5:0 (event code). A control read returns those bits in the same positions. Bit 13 and every other bit, including 31:16, read 0.
- R3: A counter advances only when run (bit 15) and arm (bit 14) are both 1. Either bit on its own gives no counting.
- R4: With a valid selected code other than 0x23, the count rises by exactly one on each clock edge at which evt_pulse[code] is 1. Strobes on the other lines have no effect.
- R5: The accepted codes are 0x01–0x0B, 0x0D–0x1A, 0x21–0x25 and 0x27–0x29. Any other code (0x00, 0x0C, 0x1B–0x20, 0x26, 0x2A–0x3F) never advances the count, even while its strobe is 1.
- R6: Code 0x23 advances the count on every clock edge while the counter is running, whatever the strobes are.
- R7: Writing run to 0 stops the counter, and the count then holds its value.
- R8: A control write with bit 13 set zeroes the count at that edge. The clear wins over an increment on the same edge. No write can load any other count value.
- R9: The high word (0x10 for counter 1, 0x18 for counter 2) holds count[47:32] in bits 15:0, with bits 31:16 reading 0. The low word (0x14 / 0x1C) holds count[31:0]. The count wraps silently modulo 2^48.
- R10: Reading a high word captures count[31:0] of that counter. The next low-word read of that counter returns the captured value, and later low-word reads return the live value.
- R11: The two counters are independent. Writing or running one never changes the other.
- R12: Control words sit at byte offsets 0x00 and 0x04. Any offset outside the map reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (triggers the shadow capture) |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| evt_pulse | input | 64 | Event strobes, bit n for event code n |
| bus_rdata | output | 32 | Read data, a combinational function of bus_addr and state |

## Verification
The properties assume the bus never asserts a read and a write in the same cycle, and that bus_addr, bus_wdata and evt_pulse are settled at every rising edge. The bench meets this by driving each input only at falling edges and by running one bus operation per cycle through its read and write tasks. The strobe vector is held at zero outside the pulse windows. The step and hold properties also take as given that nothing outside a control write touches the count. This lets a plain one-cycle history describe every legal change of the count.

// File: rtl/perf_evt_pair.sv
module perf_evt_pair #(
  parameter int CNT_W     = 48,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int CODE_W    = 6,
  parameter int TIME_CODE = 35
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic [(1<<CODE_W)-1:0]  evt_pulse,
  output logic [DATA_W-1:0]       bus_rdata
);
  localparam int HI_W  = CNT_W - DATA_W;
  localparam int RUN_B = 15;
  localparam int ARM_B = 14;
  localparam int CLR_B = 13;
  localparam int CKS_B = 8;
  localparam int N_CTR = 2;

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    int v;
    v = int'(c);
    return (v >= 1  && v <= 11) || (v >= 13 && v <= 26) ||
           (v >= 33 && v <= 37) || (v >= 39 && v <= 41);
  endfunction

  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[DATA_W-1:16], bus_wdata[12:9], bus_wdata[7:CODE_W]};

  logic [DATA_W-1:0] ctl_word [N_CTR];
  logic [DATA_W-1:0] hi_word  [N_CTR];
  logic [DATA_W-1:0] lo_word  [N_CTR];

  for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
    logic              run_q, arm_q, cks_q, shv_q;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shd_q;
    logic              ctl_wr, clr, hi_rd, lo_rd, hit, inc;

    assign ctl_wr = bus_wr && (bus_addr == ADDR_W'(4 * i));
    assign clr    = ctl_wr && bus_wdata[CLR_B];
    assign hi_rd  = bus_rd && (bus_addr == ADDR_W'(16 + 8 * i));
    assign lo_rd  = bus_rd && (bus_addr == ADDR_W'(20 + 8 * i));
    assign hit    = (int'(code_q) == TIME_CODE) ? 1'b1 : evt_pulse[code_q];
    assign inc    = run_q && arm_q && code_ok(code_q) && hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q  <= 1'b0;
        arm_q  <= 1'b0;
        cks_q  <= 1'b0;
        code_q <= '0;
      end else if (ctl_wr) begin
        run_q  <= bus_wdata[RUN_B];
        arm_q  <= bus_wdata[ARM_B];
        cks_q  <= bus_wdata[CKS_B];
        code_q <= bus_wdata[CODE_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_q <= '0;
        shv_q <= 1'b0;
      end else if (hi_rd) begin
        shd_q <= cnt[DATA_W-1:0];
        shv_q <= 1'b1;
      end else if (lo_rd) begin
        shv_q <= 1'b0;
      end
    end

    always_comb begin
      ctl_word[i]                = '0;
      ctl_word[i][RUN_B]         = run_q;
      ctl_word[i][ARM_B]         = arm_q;
      ctl_word[i][CKS_B]         = cks_q;
      ctl_word[i][CODE_W-1:0]    = code_q;
    end
    assign hi_word[i] = DATA_W'(cnt[CNT_W-1:CNT_W-HI_W]);
    assign lo_word[i] = shv_q ? shd_q : cnt[DATA_W-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_CTR; i++) begin
      if (bus_addr == ADDR_W'(4 * i))      bus_rdata = ctl_word[i];
      if (bus_addr == ADDR_W'(16 + 8 * i)) bus_rdata = hi_word[i];
      if (bus_addr == ADDR_W'(20 + 8 * i)) bus_rdata = lo_word[i];
    end
  end
endmodule

module perf_evt_pair_chk #(
  parameter int CNT_W  = 48,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              run0,
  input logic              arm0,
  input logic [CODE_W-1:0] code0,
  input logic [CNT_W-1:0]  cnt0,
  input logic              run1,
  input logic              arm1,
  input logic [CNT_W-1:0]  cnt1
);
  logic clr0, clr1, bad0;
  assign clr0 = bus_wr && bus_addr == ADDR_W'(0) && bus_wdata[13];
  assign clr1 = bus_wr && bus_addr == ADDR_W'(4) && bus_wdata[13];
  assign bad0 = code0 inside {6'h00, 6'h0C, [6'h1B:6'h20], 6'h26, [6'h2A:6'h3F]};

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr0 |=> cnt0 == '0);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(run0 && arm0) && !clr0 |=> cnt0 == $past(cnt0));
  assert_bad_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bad0 && !clr0 |=> cnt0 == $past(cnt0));
  assert_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run0 && arm0 && code0 == 6'h23 && !clr0 |=> cnt0 == $past(cnt0) + 1'b1);
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr0 |=> (cnt0 == $past(cnt0)) || (cnt0 == $past(cnt0) + 1'b1));
  assert_indep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(run1 && arm1) && !clr1 |=> cnt1 == $past(cnt1));
  assert_hi_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (bus_addr == ADDR_W'(16) || bus_addr == ADDR_W'(24)) |-> bus_rdata[DATA_W-1:16] == '0);
  assert_ctl_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (bus_addr == ADDR_W'(0) || bus_addr == ADDR_W'(4)) |-> (bus_rdata & ~DATA_W'(32'hC13F)) == '0);
endmodule

bind perf_evt_pair perf_evt_pair_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .run0(g_ctr[0].run_q), .arm0(g_ctr[0].arm_q), .code0(g_ctr[0].code_q), .cnt0(g_ctr[0].cnt),
  .run1(g_ctr[1].run_q), .arm1(g_ctr[1].arm_q), .cnt1(g_ctr[1].cnt)
);

// File: tb/sim_perf_evt_pair.sv
module sim_perf_evt_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [63:0] evt_pulse = '0;
  logic [31:0] bus_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  perf_evt_pair u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .evt_pulse(evt_pulse), .bus_rdata(bus_rdata));

  // {code[7:0], pulses[3:0], expected[3:0]}
  localparam logic [15:0] VEC [0:15] = '{
    16'h0133, 16'h0C40, 16'h0B55, 16'h0D22, 16'h1A33, 16'h1B40, 16'h2020, 16'h2166,
    16'h2345, 16'h2511, 16'h2630, 16'h2922, 16'h0030, 16'h2A20, 16'h3F20, 16'h1777};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state of every mapped register
    foreach (VEC[k]) if (k < 6) begin
      logic [4:0] a;
      a = (k < 2) ? 5'(4 * k) : 5'(16 + 4 * (k - 2));
      rd(a, d); check("R1 reset", d, 32'h0);
    end

    // R4 R5 R6: table walk, alternating counters
    for (int k = 0; k < 16; k++) begin
      logic [4:0] base;
      logic [5:0] code;
      int np;
      base = 5'(4 * (k % 2));
      code = VEC[k][13:8];
      np   = int'(VEC[k][7:4]);
      wr(base, 32'h2000);
      wr(base, 32'hC000 | 32'(code));
      for (int j = 0; j < np; j++) begin
        evt_pulse = 64'd1 << code;
        @(negedge clk);
        evt_pulse = '0;
      end
      wr(base, 32'(code));
      rd(5'(16 + 2 * base), d); check("R9 table hi", d, 32'h0);
      rd(5'(20 + 2 * base), d); check("R4 R5 R6 table count", d, 32'(VEC[k][3:0]));
    end

    // R2: control readback masks
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, d); check("R2 ctl readback", d, 32'h0000_C13F);
    wr(5'h00, 32'h0000_0000);
    rd(5'h00, d); check("R2 ctl cleared", d, 32'h0);

    // R3: arm alone or run alone does not count
    wr(5'h00, 32'h2000);
    wr(5'h00, 32'h4023); idle(5);
    wr(5'h00, 32'h8023); idle(5);
    wr(5'h00, 32'h0023);
    rd(5'h14, d); check("R3 half enable", d, 32'h0);

    // R4: strobes on other lines ignored
    wr(5'h00, 32'h2000);
    wr(5'h00, 32'hC002);
    evt_pulse = ~(64'd1 << 2); idle(4); evt_pulse = '0;
    wr(5'h00, 32'h0002);
    rd(5'h14, d); check("R4 other strobes", d, 32'h0);

    // R6 R7 R11: elapsed count on counter 2, hold after stop, counter 1 untouched
    wr(5'h04, 32'h2000);
    wr(5'h04, 32'hC023); idle(9);
    wr(5'h04, 32'h0023);
    rd(5'h1C, d); check("R6 elapsed", d, 32'd10);
    idle(6);
    rd(5'h1C, d); check("R7 hold", d, 32'd10);
    rd(5'h14, d); check("R11 independence", d, 32'h0);

    // R8: clear wins over increment; clear bit reads 0
    wr(5'h00, 32'h2000);
    wr(5'h00, 32'hC023); idle(3);
    wr(5'h00, 32'hE023);
    wr(5'h00, 32'h0023);
    rd(5'h14, d); check("R8 clear priority", d, 32'd1);
    rd(5'h00, d); check("R8 clear bit reads 0", d, 32'h0000_0023);

    // R10: shadow snapshot
    wr(5'h00, 32'h2000);
    wr(5'h00, 32'hC023); idle(3);
    rd(5'h10, d); check("R10 hi", d, 32'h0);
    idle(5);
    rd(5'h14, d); check("R10 shadow lo", d, 32'd3);
    rd(5'h14, d); check("R10 live lo", d, 32'd10);
    wr(5'h00, 32'h0023);

    // R12: unmapped offsets
    rd(5'h08, d); check("R12 unmapped 08", d, 32'h0);
    rd(5'h0C, d); check("R12 unmapped 0C", d, 32'h0);

    finish_run();
  end
endmodule